// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block executes the write-side operations of a serial NOR flash model once a command front end has decoded them: programming part of a page, erasing one sector, or erasing the whole array. The front end announces a request with an operation code and an address. For a program, it then streams the data bytes. It then signals the end of the command, which is the point where chip select returns high. At that point the engine checks three things: the write-enable latch, the block-protection setting and, for a program, whether any data arrived. If all pass, it runs a timed busy cycle. The write-in-progress flag is high for the whole cycle. At the end of the cycle the flag drops and the write-enable latch clears.

The array is a behavioural byte store addressed as {sector, page, column}. It holds erased bytes (FFh) after reset. Programming can only turn 1 bits into 0 bits. Erase always covers a whole sector or the whole array. A single read port lets the surrounding logic, or a bench, observe the contents. The geometry and the three busy durations are parameters. The defaults are kept small so the array elaborates quickly.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, `wip` and `wel` are 0 and every array byte reads FFh.
- R2: While `wip` is 0, `wel_clr` clears the write-enable latch and `wel_set` sets it. If both are high in the same cycle, the clear wins. The new value appears on `wel` one clock later.
- R3: A pulse on `cs_rise` while idle starts a busy cycle only if all of these hold: `wel` is 1, a request is pending, and the target is not protected. The request's `req_op` encodes 01 program, 10 sector erase and 11 bulk erase. When the cycle starts, `wip` is 1 from the next clock. Any `cs_rise` while idle discards the pending request.
- R4: `wip` stays high for exactly PP_CYCLES clocks after a program, SE_CYCLES after a sector erase and BE_CYCLES after a bulk erase. `wel` reads 0 on the cycle where `wip` falls.
- R5: A program writes the stored byte AND the new byte. The first byte goes to the column in the low address bits, and each later byte goes to the next column. After the last column of the page, the column wraps to column 0. If more than PG_BYTES bytes are sent, only the last PG_BYTES are kept.
- R6: A sector erase sets every byte of the sector selected by the top address bits to FFh, whatever the lower address bits are. All other sectors are left unchanged.
- R7: A bulk erase sets every byte of the array to FFh.
- R8: Sector s is protected when `prot_bits` is nonzero and s ≥ SECT_CNT − min(SECT_CNT, 2^(prot_bits−1)). A program or sector erase aimed at a protected sector does not start: `wip` stays 0, the array is unchanged and `wel` stays 1.
- R9: A bulk erase does not start while `prot_bits` is nonzero.
- R10: While `wip` is 1, `wel_set`, `wel_clr`, `req_valid`, `dat_valid` and `cs_rise` have no effect.
- R11: A program request that receives no data byte before `cs_rise` does not start, and `wel` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| req_valid | input | 1 | Start of a request; latches `req_op` and `req_addr` |
| req_op | input | 2 | 01 program, 10 sector erase, 11 bulk erase |
| req_addr | input | ADDR_W | Byte address {sector, page, column} |
| dat_valid | input | 1 | One program data byte is present |
| dat_byte | input | 8 | Program data byte |
| cs_rise | input | 1 | End of command; evaluate and start the request |
| prot_bits | input | 3 | Block-protection level |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |

## Verification
A wrong busy counter changes the width of the `wip` pulse by whole clocks. A missed clear of the latch leaves `wel` high on the cycle where `wip` falls. Both show up within one busy period. A wrong column pointer, a wrong sector base or a wrong protection decode leaves the wrong bytes in the array. That shows on `rd_data` as soon as the read address reaches the affected byte after `wip` drops, which is at most one array sweep later. A rejected operation that starts anyway shows up at once, because `wip` rises one clock after `cs_rise`.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_PROG = 2'b01,
      OP_SECT = 2'b10,
      OP_BULK = 2'b11
   } fpe_op_e;
endpackage

// File: rtl/fpe_cell_array.sv
module fpe_cell_array #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] ra,
   output logic [7:0]    rda,
   input  logic [AW-1:0] rb,
   output logic [7:0]    rdb
);
   logic [7:0] cells [DEPTH];

   // reset models the erased state of a fresh array
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rda = cells[ra];
   assign rdb = cells[rb];
endmodule

// File: rtl/fpe_page_buf.sv
module fpe_page_buf #(
   parameter int PG_BYTES = 16,
   localparam int COL_W   = $clog2(PG_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [COL_W-1:0] start_col,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic [COL_W-1:0] rd_col,
   output logic [7:0]       rd_byte,
   output logic             has_data
);
   logic [7:0]       slots [PG_BYTES];
   logic [COL_W-1:0] ptr;

   // unwritten slots hold FFh so the AND leaves those cells alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PG_BYTES; i++) slots[i] <= 8'hFF;
         ptr      <= '0;
         has_data <= 1'b0;
      end else if (clear) begin
         for (int i = 0; i < PG_BYTES; i++) slots[i] <= 8'hFF;
         ptr      <= start_col;
         has_data <= 1'b0;
      end else if (wr_en) begin
         slots[ptr] <= wr_byte;
         ptr        <= ptr + 1'b1;   // power-of-two page: natural wrap
         has_data   <= 1'b1;
      end
   end

   assign rd_byte = slots[rd_col];

   AST_BUF_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !has_data);   // R11
endmodule

// File: rtl/fpe_prot_map.sv
module fpe_prot_map #(
   parameter int SECT_CNT = 8,
   parameter int BP_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BP_W-1:0]     bp,
   output logic [SECT_CNT-1:0] prot_vec,
   output logic                prot_any
);
   int nprot;

   always_comb begin
      if (bp == '0) nprot = 0;
      else if (int'(bp) - 1 >= $clog2(SECT_CNT)) nprot = SECT_CNT;
      else nprot = 1 << (int'(bp) - 1);
   end

   for (genvar s = 0; s < SECT_CNT; s++) begin : g_sect
      assign prot_vec[s] = (s >= SECT_CNT - nprot);
      if (s < SECT_CNT - 1) begin : g_contig
         AST_PROT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
            prot_vec[s] |-> prot_vec[s+1]);   // R8
      end
   end

   assign prot_any = |prot_vec;

   AST_PROT_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bp != '0) |-> prot_vec[SECT_CNT-1]);   // R8
endmodule

// File: rtl/fpe_busy_timer.sv
module fpe_busy_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] dur,
   output logic             active,
   output logic [CNT_W-1:0] step,
   output logic             done
);
   logic [CNT_W-1:0] lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         step   <= '0;
         lim    <= '0;
      end else if (start) begin
         active <= 1'b1;
         step   <= '0;
         lim    <= dur - CNT_W'(1);
      end else if (active) begin
         if (step == lim) active <= 1'b0;
         else             step   <= step + CNT_W'(1);
      end
   end

   assign done = active && (step == lim);

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (step <= lim));   // R4
   AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !active);   // R4
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
   import flash_pe_pkg::*;
#(
   parameter int SECT_CNT    = 8,
   parameter int PG_PER_SECT = 2,
   parameter int PG_BYTES    = 16,
   parameter int PP_CYCLES   = 20,
   parameter int SE_CYCLES   = 40,
   parameter int BE_CYCLES   = 300,
   localparam int COL_W      = $clog2(PG_BYTES),
   localparam int PGI_W      = $clog2(PG_PER_SECT),
   localparam int SEC_W      = $clog2(SECT_CNT),
   localparam int ADDR_W     = SEC_W + PGI_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              dat_valid,
   input  logic [7:0]        dat_byte,
   input  logic              cs_rise,
   input  logic [2:0]        prot_bits,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              wip,
   output logic              wel
);
   localparam int SECT_BYTES = PG_PER_SECT * PG_BYTES;
   localparam int TOTAL      = SECT_CNT * SECT_BYTES;
   localparam int MAX_DUR    = (BE_CYCLES > SE_CYCLES) ?
                               ((BE_CYCLES > PP_CYCLES) ? BE_CYCLES : PP_CYCLES) :
                               ((SE_CYCLES > PP_CYCLES) ? SE_CYCLES : PP_CYCLES);
   localparam int CNT_W      = $clog2(MAX_DUR + 1);
   localparam int HI_W       = ADDR_W - COL_W;

   // elaboration-time parameter checks
   if (PG_BYTES < 2 || (PG_BYTES & (PG_BYTES - 1)) != 0) begin : g_bad_pg
      $error("PG_BYTES must be a power of two of at least 2");
   end
   if (PG_PER_SECT < 2 || (PG_PER_SECT & (PG_PER_SECT - 1)) != 0) begin : g_bad_pps
      $error("PG_PER_SECT must be a power of two of at least 2");
   end
   if (SECT_CNT < 2 || (SECT_CNT & (SECT_CNT - 1)) != 0) begin : g_bad_sc
      $error("SECT_CNT must be a power of two of at least 2");
   end
   if (PP_CYCLES < PG_BYTES) begin : g_bad_pp
      $error("PP_CYCLES must cover one write per page byte");
   end
   if (SE_CYCLES < SECT_BYTES) begin : g_bad_se
      $error("SE_CYCLES must cover one write per sector byte");
   end
   if (BE_CYCLES < TOTAL) begin : g_bad_be
      $error("BE_CYCLES must cover one write per array byte");
   end

   fpe_op_e           pend_op;
   logic [HI_W-1:0]   pend_hi;
   fpe_op_e           run_op;
   logic [ADDR_W-1:0] run_base;
   logic              wel_q;
   logic              busy, done, idle, go, blocked, buf_has;
   logic [CNT_W-1:0]  step, dur, span;
   logic [SECT_CNT-1:0] prot_vec;
   logic              prot_any;
   logic [SEC_W-1:0]  pend_sect;
   logic              buf_clear, buf_wr;
   logic [7:0]        buf_byte, cell_old, wdata;
   logic [ADDR_W-1:0] waddr;
   logic              we;

   assign idle      = !busy;
   assign pend_sect = pend_hi[HI_W-1 -: SEC_W];

   fpe_prot_map #(.SECT_CNT(SECT_CNT), .BP_W(3)) u_prot (
      .clk(clk), .rst_n(rst_n), .bp(prot_bits),
      .prot_vec(prot_vec), .prot_any(prot_any));

   always_comb begin
      case (pend_op)
         OP_PROG, OP_SECT: blocked = prot_vec[pend_sect];
         OP_BULK:          blocked = prot_any;
         default:          blocked = 1'b1;
      endcase
   end

   assign go = idle && cs_rise && wel_q && !blocked &&
               ((pend_op != OP_PROG) || buf_has);

   always_comb begin
      case (pend_op)
         OP_PROG: dur = CNT_W'(PP_CYCLES);
         OP_SECT: dur = CNT_W'(SE_CYCLES);
         default: dur = CNT_W'(BE_CYCLES);
      endcase
   end

   always_comb begin
      case (run_op)
         OP_PROG: span = CNT_W'(PG_BYTES);
         OP_SECT: span = CNT_W'(SECT_BYTES);
         OP_BULK: span = CNT_W'(TOTAL);
         default: span = '0;
      endcase
   end

   // pending request and run capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_op  <= OP_NONE;
         pend_hi  <= '0;
         run_op   <= OP_NONE;
         run_base <= '0;
      end else begin
         if (idle) begin
            if (cs_rise) begin
               pend_op <= OP_NONE;
            end else if (req_valid) begin
               pend_op <= fpe_op_e'(req_op);
               pend_hi <= req_addr[ADDR_W-1:COL_W];
            end
         end
         if (go) begin
            run_op <= pend_op;
            case (pend_op)
               OP_PROG: run_base <= {pend_hi, COL_W'(0)};
               OP_SECT: run_base <= {pend_sect, (ADDR_W-SEC_W)'(0)};
               default: run_base <= '0;
            endcase
         end
      end
   end

   // write-enable latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wel_q <= 1'b0;
      else if (done)             wel_q <= 1'b0;
      else if (idle && wel_clr)  wel_q <= 1'b0;
      else if (idle && wel_set)  wel_q <= 1'b1;
   end

   assign buf_clear = idle && !cs_rise && req_valid;
   assign buf_wr    = idle && !cs_rise && dat_valid && (pend_op == OP_PROG);

   fpe_page_buf #(.PG_BYTES(PG_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(buf_clear),
      .start_col(req_addr[COL_W-1:0]), .wr_en(buf_wr), .wr_byte(dat_byte),
      .rd_col(step[COL_W-1:0]), .rd_byte(buf_byte), .has_data(buf_has));

   fpe_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(go), .dur(dur),
      .active(busy), .step(step), .done(done));

   // one byte per busy clock, from the start of the cycle
   assign we    = busy && (step < span);
   assign waddr = run_base + ADDR_W'(step);
   assign wdata = (run_op == OP_PROG) ? (cell_old & buf_byte) : 8'hFF;

   fpe_cell_array #(.DEPTH(TOTAL), .AW(ADDR_W)) u_cells (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .ra(rd_addr), .rda(rd_data), .rb(waddr), .rdb(cell_old));

   assign wip = busy;
   assign wel = wel_q;

   AST_GO_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> wip);   // R3
   AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(wel));   // R3
   AST_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);   // R4
   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> wip);   // R10
   AST_NO_BULK_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wip) && run_op == OP_BULK) |-> $past(prot_bits == 3'd0));   // R9
   AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (we && run_op == OP_PROG) |-> ((wdata & ~cell_old) == 8'h00));   // R5
endmodule

// File: tb/flash_pe_engine_test.sv
module flash_pe_engine_test;
   localparam int SECT_CNT = 8, PG_PER_SECT = 2, PG_BYTES = 16;
   localparam int PP = 20, SE = 40, BE = 300;
   localparam int SECT_BYTES = PG_PER_SECT * PG_BYTES;
   localparam int TOTAL = SECT_CNT * SECT_BYTES;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wel_set = 0, wel_clr = 0, req_valid = 0, dat_valid = 0, cs_rise = 0;
   logic [1:0] req_op = 0;
   logic [AW-1:0] req_addr = 0, rd_addr = 0;
   logic [7:0] dat_byte = 0, rd_data;
   logic [2:0] prot_bits = 0;
   logic wip, wel;

   always #5 clk = ~clk;   // 100 MHz

   flash_pe_engine #(.SECT_CNT(SECT_CNT), .PG_PER_SECT(PG_PER_SECT), .PG_BYTES(PG_BYTES),
                     .PP_CYCLES(PP), .SE_CYCLES(SE), .BE_CYCLES(BE)) uut (
      .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .dat_valid(dat_valid), .dat_byte(dat_byte), .cs_rise(cs_rise),
      .prot_bits(prot_bits), .rd_addr(rd_addr), .rd_data(rd_data),
      .wip(wip), .wel(wel));

   int n_cmp = 0, n_bad = 0;
   bit finished = 0, armed = 0;
   string cur_req = "R1";

   // ---------------- reference model ----------------
   int m_mem [TOTAL];
   int m_left, m_pend, m_paddr, m_n, m_rop, m_raddr, m_rn;
   bit m_wel;
   int m_q[$];
   int m_rq[$];

   function automatic bit m_prot(int bp, int s);
      int n;
      if (bp == 0) return 0;
      n = 1 << (bp - 1);
      if (n > SECT_CNT) n = SECT_CNT;
      return s >= SECT_CNT - n;
   endfunction

   task automatic m_apply();
      int base, col;
      if (m_rop == 1) begin
         base = (m_raddr / PG_BYTES) * PG_BYTES;
         for (int j = 0; j < m_rq.size(); j++) begin
            col = ((m_raddr % PG_BYTES) + (m_rn - m_rq.size() + j)) % PG_BYTES;
            m_mem[base + col] = m_mem[base + col] & m_rq[j];
         end
      end else if (m_rop == 2) begin
         base = (m_raddr / SECT_BYTES) * SECT_BYTES;
         for (int i = 0; i < SECT_BYTES; i++) m_mem[base + i] = 255;
      end else begin
         for (int i = 0; i < TOTAL; i++) m_mem[i] = 255;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_left = 0; m_wel = 0; m_pend = 0; m_n = 0;
         m_q.delete();
         for (int i = 0; i < TOTAL; i++) m_mem[i] = 255;
      end else if (m_left > 0) begin
         m_left = m_left - 1;
         if (m_left == 0) begin
            m_apply();
            m_wel = 0;
         end
      end else begin
         bit ok;
         ok = 0;
         if (cs_rise && m_pend != 0 && m_wel) begin
            if (m_pend == 3) ok = (prot_bits == 0);
            else ok = !m_prot(prot_bits, m_paddr / SECT_BYTES);
            if (m_pend == 1 && m_n == 0) ok = 0;
         end
         if (wel_clr) m_wel = 0;
         else if (wel_set) m_wel = 1;
         if (cs_rise) begin
            if (ok) begin
               m_rop = m_pend; m_raddr = m_paddr; m_rn = m_n; m_rq = m_q;
               m_left = (m_pend == 1) ? PP : (m_pend == 2) ? SE : BE;
            end
            m_pend = 0;
         end else begin
            if (req_valid) begin
               m_pend = req_op; m_paddr = req_addr; m_n = 0;
               m_q.delete();
            end else if (dat_valid && m_pend == 1) begin
               m_q.push_back(dat_byte);
               m_n++;
               if (m_q.size() > PG_BYTES) void'(m_q.pop_front());
            end
         end
      end
      armed = 1;
   end

   // ---------------- comparison, away from the edges ----------------
   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (armed && !finished) begin
         if (!rst_n) begin
            chk("R1", "wip in reset", {31'd0, wip}, 0);
            chk("R1", "wel in reset", {31'd0, wel}, 0);
         end else begin
            chk((cur_req == "R1") ? "R4" : cur_req, "wip", {31'd0, wip}, (m_left > 0) ? 1 : 0);
            chk((cur_req == "R1") ? "R2" : cur_req, "wel", {31'd0, wel}, {31'd0, m_wel});
            if (m_left == 0)
               chk(cur_req, "rd_data", {24'd0, rd_data}, m_mem[rd_addr]);
         end
      end
   end

   always @(negedge clk) rd_addr <= rd_addr + 1'b1;

   // ---------------- stimulus ----------------
   task automatic drive(bit ws, bit wc, bit rv, int op, int addr, bit dv, int b, bit cr);
      @(negedge clk);
      wel_set = ws; wel_clr = wc; req_valid = rv; req_op = 2'(op);
      req_addr = AW'(addr); dat_valid = dv; dat_byte = 8'(b); cs_rise = cr;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wset();
      drive(1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wait_done();
      idle(1);
      while (wip) idle(1);
   endtask

   task automatic sweep();
      idle(TOTAL + 2);
   endtask

   task automatic issue(int op, int addr, int nbytes, int seed);
      drive(0, 0, 1, op, addr, 0, 0, 0);
      for (int k = 0; k < nbytes; k++) drive(0, 0, 0, 0, 0, 1, (seed + k * 37) & 255, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   initial begin
      idle(5);
      rst_n = 1;
      cur_req = "R1"; sweep();

      cur_req = "R3";   // no latch: program must not start
      issue(1, 0, 4, 8'h12); wait_done(); sweep();

      cur_req = "R2";
      wset(); idle(1);
      drive(1, 1, 0, 0, 0, 0, 0, 0); idle(1);   // clear wins
      wset(); drive(0, 1, 0, 0, 0, 0, 0, 0); idle(1);
      wset(); idle(1);

      cur_req = "R5";
      issue(1, 3, 5, 8'hF3); wait_done(); sweep();
      wset(); issue(1, 3, 5, 8'h5C); wait_done(); sweep();          // AND with old data
      wset(); issue(1, 32 + 16 + 10, 20, 8'h21); wait_done(); sweep();  // wrap and overflow

      cur_req = "R11";
      wset(); issue(1, 64, 0, 0); idle(3);

      cur_req = "R6";
      issue(1, 64 + 2, 16, 8'h44); wait_done();
      wset(); issue(2, 32 + 16 + 7, 0, 0);
      cur_req = "R10";   // everything below lands while busy
      drive(0, 1, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 1, 3, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 1);
      wait_done();
      cur_req = "R6"; sweep();

      cur_req = "R8";
      wset(); prot_bits = 3'd1;
      issue(1, 7 * 32 + 5, 3, 8'h01); wait_done();     // sector 7 protected
      issue(1, 6 * 32 + 5, 3, 8'h0F); wait_done(); sweep();
      wset(); prot_bits = 3'd3;
      issue(2, 4 * 32 + 9, 0, 0); wait_done();         // sector 4 protected
      issue(1, 3 * 32, 4, 8'h70); wait_done();
      wset(); issue(2, 3 * 32 + 30, 0, 0); wait_done(); sweep();
      wset(); prot_bits = 3'd5;
      issue(1, 0, 2, 8'h00); wait_done(); sweep();     // clamp: all protected

      cur_req = "R9";
      prot_bits = 3'd2;
      issue(3, 0, 0, 0); wait_done(); sweep();

      cur_req = "R7";
      prot_bits = 3'd0;
      issue(3, 17, 0, 0); wait_done(); sweep();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule